// File: doc/BRIEF.md
# Peak/Charge Particle Discriminator

This block labels each detected scintillator pulse as a neutron or a gamma event. It sees a stream of shaped samples, meaning trapezoid-like filter output. Each event is framed by a start mark on its first sample and an end mark on its last. Over that span the block follows the largest sample, which is the peak. It also adds the samples into a saturating charge integral, ORs together the pileup indications, and keeps the timestamp presented with the start sample.

On the end sample the block compares the peak-to-charge relation with a programmable unsigned 16.16 fixed-point slope. It does this without a divider, by testing `peak * 2^16` against `slope * charge`. The result leaves as two 64-bit words on consecutive cycles. The first word is the timestamp. The second word packs the peak, the charge, a two-bit particle code and the pileup flag. A configuration bit swaps which side of the slope counts as neutron. Code 2'b10 is reserved for LED calibration pulses and is never produced.

Top module: `psd_classifier`

## Requirements
- R1: The peak field equals the maximum sample value accepted from the start-marked sample through the end-marked sample, inclusive.
- R2: The charge field equals the sum of the same samples, held at 32 bits and clamped at 0xFFFFFFFF instead of wrapping.
- R3: With `cfg_swap` low, the type code is 2'b01 (neutron) when `peak * 65536 > cfg_slope * charge`. Otherwise, including equality, it is 2'b00 (gamma). `cfg_slope` is unsigned 16.16.
- R4: With `cfg_swap` high, the two codes exchange. The relation strictly above the slope gives 2'b00 and the relation at or below it gives 2'b01.
- R5: The cycle after the end sample is accepted, `out_valid` is high with `out_second` low and `out_data` equal to the timestamp captured with the start sample. The next cycle carries the second word with `out_second` high. The cycle after that has `out_valid` low, unless a new event has ended.
- R6: Second-word layout: peak in bits 15:0, charge in bits 47:16, type in bits 49:48, zeros in bits 62:50, pileup in bit 63. Code 2'b10 (LED) never appears.
- R7: The pileup bit is the OR of `in_pileup` over all accepted samples of the event.
- R8: A cycle with `in_valid` low is ignored, even when it carries start or end marks. So is a valid sample with no open event and no start mark. Neither changes the reported result.
- R9: A start mark while an event is open discards the partial event and begins a new one, with a new timestamp.
- R10: After reset, `out_valid` and `out_second` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slope | input | 32 | Calibration slope, unsigned 16.16 |
| cfg_swap | input | 1 | Swap neutron/gamma sides of the slope |
| in_valid | input | 1 | Sample qualifier |
| in_start | input | 1 | Sample is the first of an event |
| in_end | input | 1 | Sample is the last of an event |
| in_pileup | input | 1 | Pileup seen on this sample |
| in_sample | input | 16 | Shaped sample, unsigned |
| in_ts | input | 64 | Timestamp, taken with the start sample |
| out_valid | output | 1 | Result word present |
| out_second | output | 1 | High on the second word of a result |
| out_data | output | 64 | Result word |

## Verification
The assertions assume that two accepted end samples are at least two cycles apart, so one result's pair of words never overlaps the next. The bench respects this by spending two full cycles reading out each result before it drives the next event. The assertions also assume `cfg_slope` and `cfg_swap` stay steady while a result is being formed; the bench changes them only between events. The sweeps span event lengths from 1 to 12 samples, slopes at zero, at fractions and at exact equality, and both polarities. They also insert invalid cycles carrying marks, stray valid samples outside an event, a restart in the middle of an event, and an event long enough to reach charge saturation.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int FRAC_BITS = 16;

  typedef enum logic [1:0] {
    PT_GAMMA   = 2'b00,
    PT_NEUTRON = 2'b01,
    PT_LED     = 2'b10,
    PT_RSVD    = 2'b11
  } ptype_e;
endpackage

// File: rtl/psd_pulse_tracker.sv
module psd_pulse_tracker #(
  parameter int SAMPLE_W = 16,
  parameter int CI_W     = 32,
  parameter int TS_W     = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_start,
  input  logic                in_end,
  input  logic                in_pileup,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [TS_W-1:0]     in_ts,
  output logic                ev_done,
  output logic                ev_active,
  output logic [SAMPLE_W-1:0] ev_peak,
  output logic [CI_W-1:0]     ev_ci,
  output logic                ev_pu,
  output logic [TS_W-1:0]     ev_ts
);
  localparam int PAD_W = CI_W + 1 - SAMPLE_W;

  // saturating accumulate of one sample into the charge sum
  function automatic logic [CI_W-1:0] sat_add(input logic [CI_W-1:0] acc,
                                              input logic [SAMPLE_W-1:0] smp);
    logic [CI_W:0] wide;
    wide = {1'b0, acc} + {{PAD_W{1'b0}}, smp};
    return wide[CI_W] ? {CI_W{1'b1}} : wide[CI_W-1:0];
  endfunction

  logic                active_q;
  logic [SAMPLE_W-1:0] peak_q;
  logic [CI_W-1:0]     ci_q;
  logic                pu_q;
  logic [TS_W-1:0]     ts_q;

  logic                accept;
  logic [SAMPLE_W-1:0] base_peak, nxt_peak;
  logic [CI_W-1:0]     base_ci, nxt_ci;
  logic                nxt_pu;
  logic [TS_W-1:0]     nxt_ts;

  always_comb begin
    accept    = in_valid && (in_start || active_q);
    base_peak = in_start ? '0 : peak_q;
    base_ci   = in_start ? '0 : ci_q;
    nxt_peak  = (in_sample > base_peak) ? in_sample : base_peak;
    nxt_ci    = sat_add(base_ci, in_sample);
    nxt_pu    = (in_start ? 1'b0 : pu_q) | in_pileup;
    nxt_ts    = in_start ? in_ts : ts_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      peak_q   <= '0;
      ci_q     <= '0;
      pu_q     <= 1'b0;
      ts_q     <= '0;
    end else if (accept) begin
      active_q <= !in_end;
      peak_q   <= nxt_peak;
      ci_q     <= nxt_ci;
      pu_q     <= nxt_pu;
      ts_q     <= nxt_ts;
    end
  end

  assign ev_done   = accept && in_end;
  assign ev_active = active_q;
  assign ev_peak   = nxt_peak;
  assign ev_ci     = nxt_ci;
  assign ev_pu     = nxt_pu;
  assign ev_ts     = nxt_ts;
endmodule

// File: rtl/psd_slope_judge.sv
module psd_slope_judge
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CI_W     = 32,
  parameter int SLOPE_W  = 32
) (
  input  logic [SAMPLE_W-1:0] peak,
  input  logic [CI_W-1:0]     ci,
  input  logic [SLOPE_W-1:0]  slope,
  input  logic                swap,
  output logic                above,
  output ptype_e              ptype
);
  localparam int PROD_W = CI_W + SLOPE_W;

  // peak/ci > slope/2^FRAC  <=>  peak*2^FRAC > slope*ci
  function automatic logic rel_above(input logic [SAMPLE_W-1:0] pk,
                                     input logic [CI_W-1:0] ch,
                                     input logic [SLOPE_W-1:0] sl);
    logic [PROD_W-1:0] lhs, rhs;
    lhs = PROD_W'(pk) << FRAC_BITS;
    rhs = PROD_W'(ch) * PROD_W'(sl);
    return lhs > rhs;
  endfunction

  always_comb begin
    above = rel_above(peak, ci, slope);
    ptype = (above ^ swap) ? PT_NEUTRON : PT_GAMMA;
  end
endmodule

// File: rtl/psd_result_packer.sv
module psd_result_packer
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CI_W     = 32,
  parameter int TS_W     = 64,
  parameter int WORD_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_done,
  input  logic [SAMPLE_W-1:0] ev_peak,
  input  logic [CI_W-1:0]     ev_ci,
  input  ptype_e              ev_type,
  input  logic                ev_pu,
  input  logic [TS_W-1:0]     ev_ts,
  output logic                out_valid,
  output logic                out_second,
  output logic [WORD_W-1:0]   out_data
);
  localparam int PEAK_LSB = 0;
  localparam int CI_LSB   = SAMPLE_W;
  localparam int TYPE_LSB = SAMPLE_W + CI_W;
  localparam int PU_BIT   = WORD_W - 1;

  function automatic logic [WORD_W-1:0] pack_meta(input logic [SAMPLE_W-1:0] pk,
                                                  input logic [CI_W-1:0] ch,
                                                  input ptype_e t,
                                                  input logic pu);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PEAK_LSB +: SAMPLE_W] = pk;
    w[CI_LSB +: CI_W]       = ch;
    w[TYPE_LSB +: 2]        = t;
    w[PU_BIT]               = pu;
    return w;
  endfunction

  logic [WORD_W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_second <= 1'b0;
      out_data   <= '0;
      meta_q     <= '0;
    end else if (ev_done) begin
      out_valid  <= 1'b1;
      out_second <= 1'b0;
      out_data   <= WORD_W'(ev_ts);
      meta_q     <= pack_meta(ev_peak, ev_ci, ev_type, ev_pu);
    end else if (out_valid && !out_second) begin
      out_second <= 1'b1;
      out_data   <= meta_q;
    end else begin
      out_valid  <= 1'b0;
      out_second <= 1'b0;
    end
  end
endmodule

// File: rtl/psd_classifier.sv
module psd_classifier
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CI_W     = 32,
  parameter int SLOPE_W  = 32,
  parameter int TS_W     = 64,
  parameter int WORD_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOPE_W-1:0]  cfg_slope,
  input  logic                cfg_swap,
  input  logic                in_valid,
  input  logic                in_start,
  input  logic                in_end,
  input  logic                in_pileup,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [TS_W-1:0]     in_ts,
  output logic                out_valid,
  output logic                out_second,
  output logic [WORD_W-1:0]   out_data
);
  // internal events, visible to the checker
  logic                ev_done;
  logic                ev_active;
  logic [SAMPLE_W-1:0] ev_peak;
  logic [CI_W-1:0]     ev_ci;
  logic                ev_pu;
  logic [TS_W-1:0]     ev_ts;
  logic                ev_above;
  ptype_e              ev_type;

  psd_pulse_tracker #(.SAMPLE_W(SAMPLE_W), .CI_W(CI_W), .TS_W(TS_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
    .in_pileup(in_pileup), .in_sample(in_sample), .in_ts(in_ts),
    .ev_done(ev_done), .ev_active(ev_active), .ev_peak(ev_peak),
    .ev_ci(ev_ci), .ev_pu(ev_pu), .ev_ts(ev_ts)
  );

  psd_slope_judge #(.SAMPLE_W(SAMPLE_W), .CI_W(CI_W), .SLOPE_W(SLOPE_W)) u_judge (
    .peak(ev_peak), .ci(ev_ci), .slope(cfg_slope), .swap(cfg_swap),
    .above(ev_above), .ptype(ev_type)
  );

  psd_result_packer #(.SAMPLE_W(SAMPLE_W), .CI_W(CI_W), .TS_W(TS_W),
                      .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .ev_done(ev_done), .ev_peak(ev_peak), .ev_ci(ev_ci), .ev_type(ev_type),
    .ev_pu(ev_pu), .ev_ts(ev_ts),
    .out_valid(out_valid), .out_second(out_second), .out_data(out_data)
  );
endmodule

// File: rtl/psd_classifier_chk.sv
module psd_classifier_chk #(
  parameter int SAMPLE_W = 16,
  parameter int CI_W     = 32,
  parameter int TS_W     = 64,
  parameter int WORD_W   = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ev_done,
  input logic [TS_W-1:0]     ev_ts,
  input logic                out_valid,
  input logic                out_second,
  input logic [WORD_W-1:0]   out_data
);
  localparam int TYPE_LSB = SAMPLE_W + CI_W;

  // R10
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_second);

  // R5
  done_to_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> out_valid && !out_second && out_data == WORD_W'($past(ev_ts)));

  // R5
  word1_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_second |=> out_valid && out_second);

  // R5
  word1_has_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_second |-> out_valid && $past(out_valid && !out_second));

  // R6
  led_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_second |-> !out_data[TYPE_LSB+1]);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_second |-> out_data[WORD_W-2:TYPE_LSB+2] == '0);

  // R2
  ci_covers_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_second |->
      out_data[SAMPLE_W +: CI_W] >= CI_W'(out_data[SAMPLE_W-1:0]));
endmodule

bind psd_classifier psd_classifier_chk #(
  .SAMPLE_W(SAMPLE_W), .CI_W(CI_W), .TS_W(TS_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_ts(ev_ts),
  .out_valid(out_valid), .out_second(out_second), .out_data(out_data)
);

// File: tb/sim_psd_classifier.sv
`timescale 1ns/1ps
module sim_psd_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_slope = '0;
  logic        cfg_swap = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0, in_pileup = 1'b0;
  logic [15:0] in_sample = '0;
  logic [63:0] in_ts = '0;
  logic        out_valid, out_second;
  logic [63:0] out_data;

  int nchecks = 0;
  int nerr = 0;
  bit finished = 1'b0;

  logic [15:0] sv [0:15];
  logic        pv [0:15];
  int          slen;

  always #2 clk = ~clk;

  psd_classifier u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slope(cfg_slope), .cfg_swap(cfg_swap),
    .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
    .in_pileup(in_pileup), .in_sample(in_sample), .in_ts(in_ts),
    .out_valid(out_valid), .out_second(out_second), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic st, input logic en,
                       input logic pu, input logic [15:0] s, input logic [63:0] ts);
    in_valid = v; in_start = st; in_end = en; in_pileup = pu; in_sample = s; in_ts = ts;
  endtask

  // expected type code: 1 = neutron, 0 = gamma
  function automatic logic [1:0] exp_type(input logic [15:0] pk, input logic [31:0] ci,
                                          input logic [31:0] sl, input logic sw);
    logic [63:0] scaled_peak, scaled_ci;
    logic over;
    scaled_peak = {32'd0, pk, 16'd0};
    scaled_ci   = {32'd0, ci} * {32'd0, sl};
    over = scaled_peak > scaled_ci;
    return (over != sw) ? 2'b01 : 2'b00;
  endfunction

  task automatic check_result(input logic [63:0] ts, input logic [15:0] pk,
                              input logic [31:0] ci, input logic pu,
                              input logic [31:0] sl, input logic sw);
    // now at the negedge after the end sample was taken: word 0
    chk("R5 word0 valid", {62'd0, out_valid, out_second}, 64'd2);
    chk("R5 word0 timestamp", out_data, ts);
    @(negedge clk);
    chk("R5 word1 valid", {62'd0, out_valid, out_second}, 64'd3);
    chk("R1 peak", {48'd0, out_data[15:0]}, {48'd0, pk});
    chk("R2 charge", {32'd0, out_data[47:16]}, {32'd0, ci});
    chk(sw ? "R4 swapped type" : "R3 type", {62'd0, out_data[49:48]},
        {62'd0, exp_type(pk, ci, sl, sw)});
    chk("R6 reserved bits", {51'd0, out_data[62:50]}, 64'd0);
    chk("R7 pileup", {63'd0, out_data[63]}, {63'd0, pu});
  endtask

  // sends sv[0..slen-1]; noise adds ignored cycles (R8)
  task automatic send_event(input logic [63:0] ts, input logic [31:0] sl,
                            input logic sw, input bit noise);
    logic [15:0] pk;
    longint unsigned sum;
    logic pu;
    pk = '0; sum = 0; pu = 1'b0;
    for (int i = 0; i < slen; i++) begin
      if (sv[i] > pk) pk = sv[i];
      sum += sv[i];
      pu |= pv[i];
    end
    if (sum > 64'hFFFF_FFFF) sum = 64'hFFFF_FFFF;
    @(negedge clk);
    chk("R5 idle between results", {63'd0, out_valid}, 64'd0);
    cfg_slope = sl; cfg_swap = sw;
    if (noise) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, 64'hDEAD);  // R8 stray sample
      @(negedge clk);
    end
    for (int i = 0; i < slen; i++) begin
      drive(1'b1, i == 0, i == slen - 1, pv[i], sv[i], (i == 0) ? ts : 64'hBAD);
      @(negedge clk);
      if (noise && i == 0 && slen > 1) begin
        drive(1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 64'hBEEF);  // R8 invalid marks
        @(negedge clk);
      end
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 64'h0);
    check_result(ts, pk, sum[31:0], pu, sl, sw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {62'd0, out_valid, out_second}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {62'd0, out_valid, out_second}, 64'd0);

    // R3 exact equality: single sample 100, slope 1.0 -> gamma
    slen = 1; sv[0] = 16'd100; pv[0] = 1'b0;
    send_event(64'h11, 32'h0001_0000, 1'b0, 1'b0);
    // R3 just below equality -> neutron
    send_event(64'h12, 32'h0000_FFFF, 1'b0, 1'b0);
    // R4 swapped at equality -> neutron
    send_event(64'h13, 32'h0001_0000, 1'b1, 1'b0);

    // sweep: trapezoid shapes, lengths, slopes, polarity, pileup, noise
    for (int seed = 0; seed < 60; seed++) begin
      int amp;
      logic [31:0] sl;
      longint unsigned s2;
      logic [15:0] p2;
      slen = 1 + seed % 12;
      amp = 200 + seed * 517;
      p2 = '0; s2 = 0;
      for (int i = 0; i < slen; i++) begin
        int e;
        e = i + 1;
        if (slen - i < e) e = slen - i;
        if (e > 3) e = 3;
        sv[i] = 16'(amp * e / 3 + (i * 7) % 5);
        pv[i] = (seed % 3 == 0) && (i == seed % slen);
        if (sv[i] > p2) p2 = sv[i];
        s2 += sv[i];
      end
      case (seed % 4)
        0: sl = 32'd0;
        1: sl = 32'h0000_4000;
        2: sl = 32'h0000_8000;
        default: sl = 32'(({p2, 16'd0}) / s2);  // relation equals or just above
      endcase
      send_event(64'h1000_0000_0000 + 64'(seed * 977), sl, seed % 5 == 0, seed % 2 == 1);
    end

    // R9 restart while open: partial event discarded
    @(negedge clk);
    cfg_slope = 32'h0000_8000; cfg_swap = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 16'd5000, 64'hAAAA);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'd10, 64'hBBBB);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 16'd20, 64'hCCCC);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd0);
    check_result(64'hBBBB, 16'd20, 32'd30, 1'b0, 32'h0000_8000, 1'b0);

    // R2 saturation: 65539 samples of 0xFFFF
    @(negedge clk);
    cfg_slope = 32'h0001_0000;
    for (int i = 0; i < 65539; i++) begin
      drive(1'b1, i == 0, i == 65538, 1'b0, 16'hFFFF, (i == 0) ? 64'h5A5A : 64'd0);
      @(negedge clk);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd0);
    check_result(64'h5A5A, 16'hFFFF, 32'hFFFF_FFFF, 1'b0, 32'h0001_0000, 1'b0);

    @(negedge clk);
    chk("R5 idle after last result", {63'd0, out_valid}, 64'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule